// File: doc/BRIEF.md
# Template-Match Phase Estimator

This block refines the arrival time of a detected pulse below one sample period. The front end hands it a short burst of pedestal-corrected samples from the pulse's rising edge, together with the coarse clock count at which the pulse was detected. A fixed bank of reference edges is built into the block at compile time. Each entry in the bank has the same shape but is shifted by a different fraction of the sample period.

The block scores every reference against the captured burst. The score is a sum of absolute differences (SAD), and a lower score means a closer match. The block keeps the best-scoring reference and reports it as a phase index joined to the coarse count. The search is serial, with one sample difference per clock, so a single subtractor and a single accumulator serve every template. A result takes P·K cycles plus a short pipeline tail.

Top module: `tm_phase_est`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and `stamp_o` is all zeros.
- R2: A `start_i` seen on a clock edge while `busy_o` is low captures `edge_i` and `coarse_i`, and `busy_o` is high in the following cycle.
- R3: Reference p (0 ≤ p < P) holds the value SLOPE·k + floor(SLOPE·p / P) at sample k (0 ≤ k < K). Sample k of the burst is the signed two's-complement field `edge_i[k*SAMPLE_W +: SAMPLE_W]`.
- R4: The error of reference p is the sum over k of |sample k − reference p at k|. The reported phase is the index of the reference with the smallest error.
- R5: When two or more references share the smallest error, the lowest index among them is reported.
- R6: `stamp_o` equals the captured coarse count in its upper CNT_W bits and the phase index in its lower log2(P) bits.
- R7: `done_o` is high for exactly one cycle, P·K+1 clock edges after the edge that accepted the start. `busy_o` drops on the same edge that raises `done_o`.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The running result is unchanged and no extra `done_o` pulse follows.
- R9: `stamp_o` changes only on the edge that raises `done_o`. It holds its value at all other times.
- R10: Negative sample values are compared as signed numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a search on the presented burst |
| coarse_i | input | CNT_W | Coarse clock count at pulse detection |
| edge_i | input | K*SAMPLE_W | K signed samples of the rising edge, sample k at bits k*SAMPLE_W |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| stamp_o | output | CNT_W+log2(P) | Coarse count joined to the winning phase index |

## Verification
A fault in the sample or phase counters shows up as an error total charged to the wrong template. The wrong phase then appears in `stamp_o` when `done_o` pulses, and the latency to that pulse shifts away from P·K+1 edges. An accumulator that fails to clear between templates biases every template after the first. This is exposed by bursts whose best match lies at a high index, and by exact tie bursts. A wrong busy or capture state shows as a second strobe or a corrupted stamp after a start arrives in mid-search. All of these faults are visible within one search period.

// File: rtl/tm_pkg.sv
package tm_pkg;
   // Reference edge value for phase p at sample k.
   function automatic int tm_ref(input int slope, input int nph, input int p, input int k);
      return slope * k + (slope * p) / nph;
   endfunction
endpackage

// File: rtl/tm_seq.sv
module tm_seq #(
   parameter int K = 8,
   parameter int P = 8,
   localparam int KI_W = $clog2(K),
   localparam int PH_W = $clog2(P)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_i,
   output logic            act_o,
   output logic [PH_W-1:0] ph_o,
   output logic [KI_W-1:0] k_o,
   output logic            last_k_o,
   output logic            last_all_o
);
   assign last_k_o   = (k_o == KI_W'(K - 1));
   assign last_all_o = last_k_o && (ph_o == PH_W'(P - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o <= 1'b0;
         ph_o  <= '0;
         k_o   <= '0;
      end else if (go_i) begin
         act_o <= 1'b1;
         ph_o  <= '0;
         k_o   <= '0;
      end else if (act_o) begin
         if (last_k_o) begin
            k_o  <= '0;
            ph_o <= ph_o + 1'b1;
            if (last_all_o) act_o <= 1'b0;
         end else begin
            k_o <= k_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tm_sad_acc.sv
module tm_sad_acc #(
   parameter int DW = 13,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_i,
   input  logic [DW-1:0] d_i,
   input  logic          last_i,
   output logic [AW-1:0] tot_o,
   output logic          tot_v_o
);
   logic [AW-1:0] acc_q;

   assign tot_o   = acc_q + AW'(d_i);
   assign tot_v_o = v_i && last_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (v_i) acc_q <= last_i ? '0 : tot_o;
   end
endmodule

// File: rtl/tm_min_track.sv
module tm_min_track #(
   parameter int AW   = 16,
   parameter int PH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            v_i,
   input  logic            first_i,
   input  logic [PH_W-1:0] ph_i,
   input  logic [AW-1:0]   err_i,
   output logic [PH_W-1:0] win_ph_o
);
   logic [AW-1:0]   best_err_q;
   logic [PH_W-1:0] best_ph_q;
   logic            take;

   // Strict less-than keeps the earlier (lower) index on a tie.
   assign take     = first_i || (err_i < best_err_q);
   assign win_ph_o = take ? ph_i : best_ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_err_q <= '0;
         best_ph_q  <= '0;
      end else if (v_i && take) begin
         best_err_q <= err_i;
         best_ph_q  <= ph_i;
      end
   end
endmodule

// File: rtl/tm_phase_est.sv
module tm_phase_est #(
   parameter int SAMPLE_W  = 12,
   parameter int K         = 8,
   parameter int P         = 8,
   parameter int CNT_W     = 16,
   parameter int REF_SLOPE = 256,
   localparam int PH_W     = $clog2(P),
   localparam int KI_W     = $clog2(K),
   localparam int DW       = SAMPLE_W + 1,
   localparam int AW       = DW + KI_W,
   localparam int STAMP_W  = CNT_W + PH_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [CNT_W-1:0]      coarse_i,
   input  logic [K*SAMPLE_W-1:0] edge_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic [STAMP_W-1:0]    stamp_o
);
   import tm_pkg::*;

   localparam int REF_MAX = REF_SLOPE * (K - 1) + (REF_SLOPE * (P - 1)) / P;

   if (P < 2 || (1 << PH_W) != P) begin : g_bad_p
      $error("P must be a power of two of at least 2");
   end
   if (K < 2) begin : g_bad_k
      $error("K must be at least 2");
   end
   if (REF_MAX >= (1 << (SAMPLE_W - 1))) begin : g_bad_ref
      $error("Reference edge does not fit in SAMPLE_W");
   end

   // Reference bank, constant per phase and sample.
   logic signed [SAMPLE_W-1:0] tmpl [P][K];
   for (genvar p = 0; p < P; p++) begin : g_ph
      for (genvar k = 0; k < K; k++) begin : g_smp
         assign tmpl[p][k] = SAMPLE_W'(tm_ref(REF_SLOPE, P, p, k));
      end
   end

   logic                       act, last_k, last_all, go;
   logic [PH_W-1:0]            ph;
   logic [KI_W-1:0]            kidx;
   logic signed [SAMPLE_W-1:0] samp_q [K];
   logic [CNT_W-1:0]           coarse_q;

   assign go = start_i && !busy_o;

   tm_seq #(.K(K), .P(P)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_i(go), .act_o(act),
      .ph_o(ph), .k_o(kidx), .last_k_o(last_k), .last_all_o(last_all)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= '0;
         for (int k = 0; k < K; k++) samp_q[k] <= '0;
      end else if (go) begin
         coarse_q <= coarse_i;
         for (int k = 0; k < K; k++) samp_q[k] <= edge_i[k*SAMPLE_W +: SAMPLE_W];
      end
   end

   // Absolute difference of the selected sample against the selected reference.
   logic signed [SAMPLE_W-1:0] cur_s, cur_t;
   logic signed [DW-1:0]       diff;
   logic [DW-1:0]              absd;
   assign cur_s = samp_q[kidx];
   assign cur_t = tmpl[ph][kidx];
   assign diff  = {cur_s[SAMPLE_W-1], cur_s} - {cur_t[SAMPLE_W-1], cur_t};
   assign absd  = diff[DW-1] ? DW'(-diff) : DW'(diff);

   logic            v1, lastk1, fin1;
   logic [DW-1:0]   d1;
   logic [PH_W-1:0] ph1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1     <= 1'b0;
         lastk1 <= 1'b0;
         fin1   <= 1'b0;
         d1     <= '0;
         ph1    <= '0;
      end else begin
         v1     <= act;
         lastk1 <= last_k;
         fin1   <= last_all;
         d1     <= absd;
         ph1    <= ph;
      end
   end

   logic [AW-1:0]   tot;
   logic            tot_v;
   logic [PH_W-1:0] win_ph;

   tm_sad_acc #(.DW(DW), .AW(AW)) u_acc (
      .clk(clk), .rst_n(rst_n), .v_i(v1), .d_i(d1), .last_i(lastk1),
      .tot_o(tot), .tot_v_o(tot_v)
   );

   tm_min_track #(.AW(AW), .PH_W(PH_W)) u_min (
      .clk(clk), .rst_n(rst_n), .v_i(tot_v), .first_i(ph1 == '0),
      .ph_i(ph1), .err_i(tot), .win_ph_o(win_ph)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         stamp_o <= '0;
      end else begin
         done_o <= tot_v && fin1;
         if (tot_v && fin1) stamp_o <= {coarse_q, win_ph};
      end
   end

   assign busy_o = act || v1;
endmodule

// File: rtl/tm_phase_est_chk.sv
module tm_phase_est_chk #(
   parameter int STAMP_W = 19
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               busy_o,
   input logic               done_o,
   input logic [STAMP_W-1:0] stamp_o
);
   assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   assert_no_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o);

   assert_stamp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stamp_o) |-> done_o);
endmodule

bind tm_phase_est tm_phase_est_chk #(.STAMP_W(STAMP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i),
   .busy_o(busy_o), .done_o(done_o), .stamp_o(stamp_o)
);

// File: tb/tm_phase_est_tb_top.sv
module tm_phase_est_tb_top;
   localparam int SW = 12, K = 8, P = 8, CW = 16, SLOPE = 256;
   localparam int PW = $clog2(P);

   logic            clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [CW-1:0]   coarse = '0;
   logic [K*SW-1:0] edge_v = '0;
   logic            busy, done;
   logic [CW+PW-1:0] stamp;
   int n_run = 0, n_fail = 0;
   int smp [K];

   always #10 clk = ~clk;

   tm_phase_est #(.SAMPLE_W(SW), .K(K), .P(P), .CNT_W(CW), .REF_SLOPE(SLOPE)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .coarse_i(coarse),
      .edge_i(edge_v), .busy_o(busy), .done_o(done), .stamp_o(stamp)
   );

   function automatic int refv(int p, int k);
      return SLOPE * k + (SLOPE * p) / P;
   endfunction

   function automatic int best_phase();
      int best = 0, be = -1;
      for (int p = 0; p < P; p++) begin
         int e = 0;
         for (int k = 0; k < K; k++) e += (smp[k] > refv(p, k)) ? smp[k] - refv(p, k) : refv(p, k) - smp[k];
         if (be < 0 || e < be) begin be = e; best = p; end
      end
      return best;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load();
      for (int k = 0; k < K; k++) edge_v[k*SW +: SW] = smp[k][SW-1:0];
   endtask

   // Run one search; optionally inject a start in mid-search.
   task automatic search(input int cnt, input string req, input bit inject);
      int cyc = 0, exp_ph;
      load();
      coarse = cnt[CW-1:0];
      exp_ph = best_phase();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0; cyc = 1;
      chk(busy === 1'b1, "R2 busy after start", busy, 1);
      while (!done && cyc < 4 * P * K) begin
         if (inject && cyc == 10) begin
            start = 1'b1; coarse = ~coarse;
            for (int k = 0; k < K; k++) edge_v[k*SW +: SW] = 12'h000;
         end else start = 1'b0;
         @(negedge clk); cyc++;
      end
      start = 1'b0;
      chk(cyc - 1 == P * K + 1, "R7 latency", cyc - 1, P * K + 1);
      chk(stamp === {cnt[CW-1:0], exp_ph[PW-1:0]}, req, stamp, {cnt[CW-1:0], exp_ph[PW-1:0]});
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R7 single-cycle done", done, 0);
   endtask

   task automatic t_reset();
      chk(busy === 1'b0 && done === 1'b0 && stamp === '0, "R1 reset", stamp, 0);
   endtask

   task automatic t_exact();
      for (int p = 0; p < P; p += 3) begin
         for (int k = 0; k < K; k++) smp[k] = refv(p, k);
         search(100 + p, "R4 R6 exact phase", 1'b0);
      end
      for (int k = 0; k < K; k++) smp[k] = refv(P - 1, k);
      search(16'hBEEF, "R3 R4 top phase", 1'b0);
   endtask

   task automatic t_tie();
      // Midway between phases 4 and 5: equal error, lower index expected.
      for (int k = 0; k < K; k++) smp[k] = refv(4, k) + (SLOPE / P) / 2;
      search(7, "R5 tie lower index", 1'b0);
      chk(stamp[PW-1:0] == 3'd4, "R5 tie phase", stamp[PW-1:0], 4);
   endtask

   task automatic t_noisy();
      for (int k = 0; k < K; k++) smp[k] = refv(6, k) + ((k % 3) - 1) * 9;
      search(12345, "R4 noisy burst", 1'b0);
      for (int k = 0; k < K; k++) smp[k] = refv(2, k) + ((k % 2) ? 11 : -7);
      search(54321, "R4 second noisy burst", 1'b0);
   endtask

   task automatic t_negative();
      for (int k = 0; k < K; k++) smp[k] = -300 - 5 * k;
      search(42, "R10 negative samples", 1'b0);
      chk(stamp[PW-1:0] == 0, "R10 negative phase", stamp[PW-1:0], 0);
   endtask

   task automatic t_busy();
      for (int k = 0; k < K; k++) smp[k] = refv(5, k);
      search(16'h1357, "R8 start while busy ignored", 1'b1);
      for (int i = 0; i < 2 * P * K; i++) begin
         @(negedge clk);
         if (done) chk(1'b0, "R8 extra done", 1, 0);
      end
      chk(stamp === {16'h1357, 3'd5}, "R9 stamp holds", stamp, {16'h1357, 3'd5});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_exact();
      t_tie();
      t_noisy();
      t_negative();
      t_busy();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule